// File: doc/BRIEF.md
# Signed Saturating Arithmetic Unit

This block performs 32-bit signed arithmetic that never wraps silently. It offers four operations: a saturating add, a saturating subtract, a saturating doubling of one operand, and a plain add that wraps but still records signed overflow. When a result falls outside the signed range, the saturating operations pin it to the nearest limit.

Every saturation or overflow event sets a sticky saturation flag. Only reset or an explicit clear input brings the flag back down. A datapath uses the flag to learn, after a run of operations, whether any of them lost precision.

Operations are issued with a one-cycle valid strobe. The result is registered and appears one clock after the strobe. It holds its value until the next strobe.

Top module: `sat_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes 0 and `q_flag` becomes 0.
- R2: `result` takes a new value at the clock edge where `in_valid` is high and is visible after that edge. With `in_valid` low, `result` keeps its value, whatever `q_clr` does.
- R3: Op code 2'b00 (saturating add) returns a+b. Overflow means a and b have the same sign and the sum's sign differs from a's sign. On overflow the result is 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative.
- R4: Op code 2'b01 (saturating subtract) returns a-b. Overflow means a and b have different signs and the difference's sign differs from a's sign. The clamp values are those of R3.
- R5: Op code 2'b10 (saturating double) uses only operand a. If a >= 0x40000000, the result is 0x7FFFFFFF. If a, read as signed, is <= 0xC0000000, the result is 0x80000000. Otherwise the result is a shifted left by one. Operand b is ignored.
- R6: Op code 2'b11 (recording add) returns the wrapped sum a+b with no clamping. The overflow test is the one in R3.
- R7: `q_flag` is set at the edge of any valid operation that overflows or saturates. This includes a doubling of exactly 0xC0000000, whose result is exact.
- R8: `q_flag` is sticky. Once set, it stays set across later operations that do not overflow, and across idle cycles, until a clear.
- R9: `q_clr` high at an edge clears `q_flag`. If a valid operation in the same cycle overflows, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue strobe for the operation on `op`, `a`, `b` |
| op | input | 2 | Operation code (see R3 to R6) |
| a | input | 32 | First operand, signed |
| b | input | 32 | Second operand, signed |
| q_clr | input | 1 | Clears the sticky saturation flag |
| result | output | 32 | Registered result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
On every cycle the assertions check four properties:
- the result holds while no operation is issued;
- the flag stays set without a clear, and drops after a clear on an idle cycle;
- the flag rises only after a valid operation;
- the wrapped sum and the positive doubling limit hold whenever those operations are issued.

Some behaviours only the bench scenarios show. These are the clamp direction for each operand sign, the boundaries around the doubling thresholds (0x3FFFFFFF, 0x40000000, 0xC0000000, 0xC0000001), and the priority of a set over a clear in the same cycle. The bench checks them against an independent model under directed and random operands.

// File: rtl/sat_pkg.sv
// Shared operation codes for the saturating arithmetic unit.
package sat_pkg;
    typedef enum logic [1:0] {
        SAT_ADD  = 2'b00,
        SAT_SUB  = 2'b01,
        SAT_DBL  = 2'b10,
        WRAP_ADD = 2'b11
    } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
// Signed add/subtract with overflow detection and clamping.
// Assumes two's complement operands of width W; W >= 2.
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] wrapped,
    output logic [W-1:0] clamped,
    output logic         ovf
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic signs_differ;
    logic sign_flip;

    // Raw sum or difference and the overflow condition for each direction.
    always_comb begin
        wrapped      = sub ? (a - b) : (a + b);
        signs_differ = a[W-1] ^ b[W-1];
        sign_flip    = wrapped[W-1] ^ a[W-1];
        ovf          = sign_flip & (sub ? signs_differ : ~signs_differ);
    end

    // Pick the limit nearest to the true result on overflow.
    always_comb begin
        if (ovf) clamped = a[W-1] ? NEG_LIM : POS_LIM;
        else     clamped = wrapped;
    end
endmodule

// File: rtl/sat_double.sv
// Saturating doubling of a signed value by threshold test on the input.
// Assumes W >= 3. The lower threshold is inclusive, so -2^(W-2) counts as saturation.
module sat_double #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic hi_hit;
    logic lo_hit;

    // Threshold tests: a >= 2^(W-2) and a <= -2^(W-2).
    always_comb begin
        hi_hit = ~a[W-1] & a[W-2];
        lo_hit = a[W-1] & (~a[W-2] | (a[W-3:0] == '0));
        sat    = hi_hit | lo_hit;
    end

    // Output selection between limits and the plain shift.
    always_comb begin
        if (hi_hit)      y = POS_LIM;
        else if (lo_hit) y = NEG_LIM;
        else             y = {a[W-2:0], 1'b0};
    end
endmodule

// File: rtl/sat_sticky.sv
// Sticky saturation flag: set by events, cleared only by reset or clear.
// A set in the same cycle as a clear leaves the flag set.
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic q
);
    // Flag register with clear-then-set ordering.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/sat_alu.sv
// Top of the saturating arithmetic unit. It selects among the add/subtract
// and doubling paths, registers the result on valid, and feeds overflow
// events to the sticky flag. Inputs are expected synchronous to clk.
module sat_alu
    import sat_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         q_clr,
    output logic [W-1:0] result,
    output logic         q_flag
);
    sat_op_e      op_e;
    logic [W-1:0] as_wrap, as_clamp, dbl_y;
    logic         as_ovf, dbl_sat;
    logic [W-1:0] next_res;
    logic         event_hit;

    assign op_e = sat_op_e'(op);

    sat_addsub #(.W(W)) addsub_i (
        .a       (a),
        .b       (b),
        .sub     (op_e == SAT_SUB),
        .wrapped (as_wrap),
        .clamped (as_clamp),
        .ovf     (as_ovf)
    );

    sat_double #(.W(W)) double_i (
        .a   (a),
        .y   (dbl_y),
        .sat (dbl_sat)
    );

    // Result and event selection by operation.
    always_comb begin
        unique case (op_e)
            SAT_ADD, SAT_SUB: begin next_res = as_clamp; event_hit = as_ovf;  end
            SAT_DBL:          begin next_res = dbl_y;    event_hit = dbl_sat; end
            default:          begin next_res = as_wrap;  event_hit = as_ovf;  end
        endcase
    end

    // Result register, loaded only on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= next_res;
    end

    sat_sticky flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_clr),
        .set   (in_valid & event_hit),
        .q     (q_flag)
    );
endmodule

// File: rtl/sat_alu_chk.sv
// Checker for sat_alu: relates ports across cycles.
module sat_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   op,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         q_clr,
    input logic [W-1:0] result,
    input logic         q_flag
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_clr) |=> q_flag);
    a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q_clr && !in_valid) |=> !q_flag);
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_flag) |-> $past(in_valid));
    a_r6_wrap_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> (result == $past(a) + $past(b)));
    a_r5_dbl_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10 && !a[W-1] && a[W-2]) |=> (result == POS_LIM && q_flag));
endmodule

bind sat_alu sat_alu_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .q_clr(q_clr), .result(result), .q_flag(q_flag)
);

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0, b = '0;
    logic        q_clr = 1'b0;
    logic [31:0] result;
    logic        q_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] m_res = '0;
    logic        m_q = 1'b0;

    always #10 clk = ~clk;

    sat_alu dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
                   .a(a), .b(b), .q_clr(q_clr), .result(result), .q_flag(q_flag));

    // Model: returns {event, result}.
    function automatic logic [32:0] model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint t;
        case (o)
            2'b00: t = sx + sy;
            2'b01: t = sx - sy;
            2'b10: t = 2 * sx;
            default: t = sx + sy;
        endcase
        if (o == 2'b11)
            return {(t > 64'sd2147483647 || t < -64'sd2147483648), x + y};
        if (o == 2'b10 && sx == -64'sd1073741824)
            return {1'b1, 32'h8000_0000};
        if (t > 64'sd2147483647)  return {1'b1, 32'h7FFF_FFFF};
        if (t < -64'sd2147483648) return {1'b1, 32'h8000_0000};
        return {1'b0, t[31:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] o, input logic [31:0] x,
                        input logic [31:0] y, input logic c, input string tag);
        logic [32:0] m;
        @(negedge clk);
        in_valid = v; op = o; a = x; b = y; q_clr = c;
        m = model(o, x, y);
        if (v) m_res = m[31:0];
        m_q = (m_q & ~c) | (v & m[32]);
        @(posedge clk); #1;
        chk({tag, " result"}, result, m_res);
        chk({tag, " q"}, {31'd0, q_flag}, {31'd0, m_q});
        @(negedge clk);
        in_valid = 1'b0; q_clr = 1'b0;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h7FFF_FFFF - $urandom_range(0, 3);
            1: return 32'h8000_0000 + $urandom_range(0, 3);
            2: return 32'h4000_0000 + $urandom_range(0, 2) - 1;
            3: return 32'hC000_0000 + $urandom_range(0, 2) - 1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset result", result, 32'h0);
        chk("R1 reset q", {31'd0, q_flag}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        step(1, 2'b00, 32'd5, 32'd3, 0, "R3 add plain");
        step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 0, "R3 R7 add pos clamp");
        step(1, 2'b00, 32'd1, 32'd1, 0, "R8 sticky after plain op");
        step(0, 2'b00, 32'd9, 32'd9, 0, "R8 R2 idle hold");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R9 R2 clear idle");
        step(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R3 add neg clamp");
        step(1, 2'b01, 32'd10, 32'd3, 1, "R9 clear with plain sub");
        step(1, 2'b01, 32'h8000_0000, 32'd1, 0, "R4 sub neg clamp");
        step(1, 2'b01, 32'd0, 32'h8000_0000, 1, "R4 R9 sub pos clamp set wins");
        step(0, 2'b11, 32'd0, 32'd0, 1, "R9 clear");
        step(1, 2'b10, 32'h3FFF_FFFF, 32'hDEAD_BEEF, 0, "R5 dbl below hi");
        step(1, 2'b10, 32'h4000_0000, 32'd0, 0, "R5 dbl hi");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R9 clear");
        step(1, 2'b10, 32'hC000_0001, 32'h1234_5678, 0, "R5 dbl above lo");
        step(1, 2'b10, 32'hC000_0000, 32'd0, 0, "R5 R7 dbl lo exact");
        step(0, 2'b00, 32'd0, 32'd0, 1, "R9 clear");
        step(1, 2'b11, 32'h7FFF_FFFF, 32'd1, 0, "R6 wrap overflow");
        step(1, 2'b11, 32'd7, 32'hFFFF_FFFF, 1, "R6 wrap plain");

        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), pick(), pick(),
                 $urandom_range(0, 9) == 0, "R2 R3 R4 R5 R6 R7 random");
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule